// File: doc/BRIEF.md
# USB Host Pipe Configuration Validator

This block holds the configuration registers for a set of USB host pipes. It decides in hardware whether each pipe may carry traffic. Software writes one configuration word per pipe. The word holds an enable bit, an allocate bit, the endpoint number, the transfer type, the token, a packet-size code, a bank count and an interrupt polling interval.

Every clock the block checks each pipe against its own size and bank limits, which come from parameters. It also sums the buffer space claimed by allocated pipes, in ascending pipe order, and compares the running total with the capacity of the shared packet buffer. The result is a registered valid flag per pipe. A pipe may transmit only while it is enabled and its flag is set. Once a pipe is valid, the fields that shape its buffer stop accepting writes.

The block also keeps the device address that is placed on every outgoing token. Software sets this address. A bus reset returns it to zero.

Top module: `upipe_cfg_ctrl`

## Requirements
- R1: After a synchronous reset:
  - all configuration words read back as zero;
  - every valid flag and transmit permit is 0;
  - the device address is 0;
  - every poll interval output is 0.
- R2: A configuration word is 23 bits wide, with these fields:
  - bit 0: enable;
  - bit 1: allocate;
  - bits 5:2: endpoint;
  - bits 7:6: type (0 control, 1 isochronous, 2 bulk, 3 interrupt);
  - bits 9:8: token;
  - bits 12:10: size code, giving a packet of 8 << code bytes;
  - bits 14:13: bank count;
  - bits 22:15: interval.

  A write to an invalid pipe stores the whole word. The word can be read back through `rd_pipe`/`rd_cfg` one clock after the register changes.
- R3: A pipe can be valid only if all of these hold:
  - enable is 1 and allocate is 1;
  - its size code does not exceed that pipe's maximum code;
  - its bank count is between 1 and that pipe's maximum bank count.
- R4: Each allocated, enabled pipe claims size × banks bytes. Claims are summed in ascending pipe order, whether or not the pipe passes its own limits. A pipe whose running total exceeds `BUF_BYTES` is invalid. A running total exactly equal to `BUF_BYTES` is accepted.
- R5: A valid flag follows the configuration registers with one clock of latency. Clearing enable or allocate clears the flag on the next clock. After that, all fields are writable again.
- R6: `tx_permit` for a pipe equals its stored enable bit AND its valid flag. It is never 1 for an invalid pipe, and it drops in the same cycle that the stored enable bit drops.
- R7: While a pipe is valid, a write to it changes only token, interval, enable and allocate. Endpoint, type, size code and bank count keep their old values.
- R8: A pipe's 8-bit poll interval output carries its interval field when its type is interrupt (3), and 0 for every other type. The output is registered one clock after the configuration.
- R9: With `addr_we` high and `bus_reset` low, `dev_addr` takes `addr_wdata` at the next clock edge. Otherwise `dev_addr` holds its value.
- R10: `bus_reset` clears `dev_addr` to 0 at the next edge, and it takes priority over a simultaneous address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_pipe | input | PW | Pipe selected for the write |
| wr_data | input | 23 | Configuration word to write |
| rd_pipe | input | PW | Pipe selected for readback |
| rd_cfg | output | 23 | Registered readback of the selected pipe's word |
| addr_we | input | 1 | Device address write strobe |
| addr_wdata | input | ADDR_W | New device address |
| bus_reset | input | 1 | Host-issued bus reset, clears the address |
| dev_addr | output | ADDR_W | Device address used on all tokens |
| cfg_valid | output | NUM_PIPES | Per-pipe valid flag |
| tx_permit | output | NUM_PIPES | Per-pipe transmit permit |
| poll_ivl | output | 8·NUM_PIPES | Per-pipe effective polling interval |

## Verification
The bench uses the default build: four pipes, a 2048-byte buffer, maximum size codes 6/7/6/4 and maximum bank counts 1/3/2/2 for pipes 0 to 3.

With these values a few four-pipe layouts land on the capacity edge. One layout sums to exactly 2048 bytes. In another, inserting pipe 2 pushes only the later pipe 3 past the limit, so the ascending-order rule can be seen.

The same limits let single-field overruns be tested on their own: a code one above its maximum, a bank count one above its maximum, and a bank count of zero.

// File: rtl/upipe_pkg.sv
package upipe_pkg;

  localparam int CFG_W = 23;

  typedef enum logic [1:0] {
    XFER_CTRL = 2'd0,
    XFER_ISO  = 2'd1,
    XFER_BULK = 2'd2,
    XFER_INTR = 2'd3
  } xfer_e;

  // Packed MSB first: interval at the top, enable at bit 0.
  typedef struct packed {
    logic [7:0] ivl;
    logic [1:0] banks;
    logic [2:0] size;
    logic [1:0] token;
    xfer_e      xtype;
    logic [3:0] ep;
    logic       alloc;
    logic       en;
  } pipe_cfg_t;

  // Keep the buffer-shaping fields of the old word; take the rest from the new one.
  function automatic pipe_cfg_t merge_locked(pipe_cfg_t old_w, pipe_cfg_t new_w);
    pipe_cfg_t r;
    r       = new_w;
    r.ep    = old_w.ep;
    r.xtype = old_w.xtype;
    r.size  = old_w.size;
    r.banks = old_w.banks;
    return r;
  endfunction

endpackage

// File: rtl/upipe_cfg_regs.sv
module upipe_cfg_regs
  import upipe_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  localparam int PW = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [PW-1:0]                   wr_pipe,
  input  pipe_cfg_t                       wr_word,
  input  logic [NUM_PIPES-1:0]            valid_q,
  output pipe_cfg_t [NUM_PIPES-1:0]       cfg_q
);

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic hit;
    assign hit = wr_en && (wr_pipe == PW'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[p] <= '0;
      end else if (hit) begin
        cfg_q[p] <= valid_q[p] ? merge_locked(cfg_q[p], wr_word) : wr_word;
      end
    end
  end

endmodule

// File: rtl/upipe_alloc_chk.sv
module upipe_alloc_chk
  import upipe_pkg::*;
#(
  parameter int                       NUM_PIPES      = 4,
  parameter int                       BUF_BYTES      = 2048,
  parameter logic [NUM_PIPES*3-1:0]   PIPE_MAX_CODE  = 12'b100_110_111_110,
  parameter logic [NUM_PIPES*2-1:0]   PIPE_MAX_BANKS = 8'b10_10_11_01,
  localparam int SUM_W = $clog2(NUM_PIPES * 3 * 1024 + BUF_BYTES + 1) + 1
) (
  input  pipe_cfg_t [NUM_PIPES-1:0] cfg,
  output logic [NUM_PIPES-1:0]      valid_nxt
);

  logic [SUM_W-1:0] run_total;
  logic [SUM_W-1:0] claim;
  logic             taken;
  logic             in_lim;

  always_comb begin
    run_total = '0;
    claim     = '0;
    taken     = 1'b0;
    in_lim    = 1'b0;
    valid_nxt = '0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      taken     = cfg[p].en & cfg[p].alloc;
      claim     = taken ? ((SUM_W'(8) << cfg[p].size) * SUM_W'(cfg[p].banks)) : '0;
      run_total = run_total + claim;
      in_lim    = (cfg[p].size <= PIPE_MAX_CODE[p*3 +: 3]) &&
                  (cfg[p].banks != 2'd0) &&
                  (cfg[p].banks <= PIPE_MAX_BANKS[p*2 +: 2]);
      valid_nxt[p] = taken && in_lim && (run_total <= SUM_W'(BUF_BYTES));
    end
  end

endmodule

// File: rtl/upipe_dev_addr.sv
module upipe_dev_addr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      addr_q <= '0;
    end else if (we) begin
      addr_q <= wdata;
    end
  end

endmodule

// File: rtl/upipe_cfg_ctrl.sv
module upipe_cfg_ctrl
  import upipe_pkg::*;
#(
  parameter int                       NUM_PIPES      = 4,
  parameter int                       BUF_BYTES      = 2048,
  parameter logic [NUM_PIPES*3-1:0]   PIPE_MAX_CODE  = 12'b100_110_111_110,
  parameter logic [NUM_PIPES*2-1:0]   PIPE_MAX_BANKS = 8'b10_10_11_01,
  parameter int                       ADDR_W         = 7,
  localparam int PW = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [PW-1:0]          wr_pipe,
  input  logic [CFG_W-1:0]       wr_data,
  input  logic [PW-1:0]          rd_pipe,
  output logic [CFG_W-1:0]       rd_cfg,
  input  logic                   addr_we,
  input  logic [ADDR_W-1:0]      addr_wdata,
  input  logic                   bus_reset,
  output logic [ADDR_W-1:0]      dev_addr,
  output logic [NUM_PIPES-1:0]   cfg_valid,
  output logic [NUM_PIPES-1:0]   tx_permit,
  output logic [NUM_PIPES*8-1:0] poll_ivl
);

  localparam int LOCK_W = 11;

  pipe_cfg_t [NUM_PIPES-1:0] cfg_q;
  logic [NUM_PIPES-1:0]      valid_nxt;
  logic [NUM_PIPES-1:0]      valid_q;
  logic [NUM_PIPES-1:0]      en_vec;
  logic [NUM_PIPES-1:0]      alloc_vec;
  logic [NUM_PIPES*LOCK_W-1:0] lock_vec;

  upipe_cfg_regs #(.NUM_PIPES(NUM_PIPES)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_pipe (wr_pipe),
    .wr_word (pipe_cfg_t'(wr_data)),
    .valid_q (valid_q),
    .cfg_q   (cfg_q)
  );

  upipe_alloc_chk #(
    .NUM_PIPES      (NUM_PIPES),
    .BUF_BYTES      (BUF_BYTES),
    .PIPE_MAX_CODE  (PIPE_MAX_CODE),
    .PIPE_MAX_BANKS (PIPE_MAX_BANKS)
  ) alloc_i (
    .cfg       (cfg_q),
    .valid_nxt (valid_nxt)
  );

  upipe_dev_addr #(.ADDR_W(ADDR_W)) addr_i (
    .clk       (clk),
    .rst       (rst),
    .bus_reset (bus_reset),
    .we        (addr_we),
    .wdata     (addr_wdata),
    .addr_q    (dev_addr)
  );

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_out
    assign en_vec[p]    = cfg_q[p].en;
    assign alloc_vec[p] = cfg_q[p].alloc;
    assign lock_vec[p*LOCK_W +: LOCK_W] =
      {cfg_q[p].ep, cfg_q[p].xtype, cfg_q[p].size, cfg_q[p].banks};

    always_ff @(posedge clk) begin
      if (rst) begin
        poll_ivl[p*8 +: 8] <= '0;
      end else begin
        poll_ivl[p*8 +: 8] <= (cfg_q[p].xtype == XFER_INTR) ? cfg_q[p].ivl : 8'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      rd_cfg  <= '0;
    end else begin
      valid_q <= valid_nxt;
      rd_cfg  <= cfg_q[rd_pipe];
    end
  end

  assign cfg_valid = valid_q;
  assign tx_permit = en_vec & valid_q;

endmodule

// File: rtl/upipe_cfg_chk.sv
module upipe_cfg_chk #(
  parameter int NUM_PIPES = 4,
  parameter int ADDR_W    = 7,
  parameter int LOCK_W    = 11
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_reset,
  input logic                        addr_we,
  input logic [ADDR_W-1:0]           dev_addr,
  input logic [NUM_PIPES-1:0]        cfg_valid,
  input logic [NUM_PIPES-1:0]        tx_permit,
  input logic [NUM_PIPES-1:0]        en_vec,
  input logic [NUM_PIPES-1:0]        alloc_vec,
  input logic [NUM_PIPES*LOCK_W-1:0] lock_vec
);

  AST_PERMIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (tx_permit & ~cfg_valid) == '0); // R6

  AST_VALID_NEEDS_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid & ~$past(en_vec & alloc_vec)) == '0); // R3

  AST_BUS_RESET_ADDR: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (dev_addr == '0)); // R10

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!addr_we && !bus_reset) |=> $stable(dev_addr)); // R9

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_lock
    AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (rst)
      cfg_valid[p] |=> $stable(lock_vec[p*LOCK_W +: LOCK_W])); // R7
  end

endmodule

bind upipe_cfg_ctrl upipe_cfg_chk #(
  .NUM_PIPES (NUM_PIPES),
  .ADDR_W    (ADDR_W),
  .LOCK_W    (LOCK_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_reset (bus_reset),
  .addr_we   (addr_we),
  .dev_addr  (dev_addr),
  .cfg_valid (cfg_valid),
  .tx_permit (tx_permit),
  .en_vec    (en_vec),
  .alloc_vec (alloc_vec),
  .lock_vec  (lock_vec)
);

// File: tb/upipe_cfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module upipe_cfg_ctrl_tb_top;

  localparam int NP = 4;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_pipe = '0;
  logic [22:0]   wr_data = '0;
  logic [1:0]    rd_pipe = '0;
  logic [22:0]   rd_cfg;
  logic          addr_we = 1'b0;
  logic [AW-1:0] addr_wdata = '0;
  logic          bus_reset = 1'b0;
  logic [AW-1:0] dev_addr;
  logic [NP-1:0] cfg_valid;
  logic [NP-1:0] tx_permit;
  logic [NP*8-1:0] poll_ivl;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  upipe_cfg_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pipe(wr_pipe), .wr_data(wr_data),
    .rd_pipe(rd_pipe), .rd_cfg(rd_cfg), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .bus_reset(bus_reset), .dev_addr(dev_addr), .cfg_valid(cfg_valid),
    .tx_permit(tx_permit), .poll_ivl(poll_ivl)
  );

  function automatic logic [22:0] mk(logic en, logic al, logic [3:0] ep, logic [1:0] ty,
                                     logic [1:0] tk, logic [2:0] sz, logic [1:0] bk,
                                     logic [7:0] iv);
    return {iv, bk, sz, tk, ty, ep, al, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Write one pipe; returns at the negedge right after the write edge.
  task automatic wr(int p, logic [22:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_pipe = 2'(p); wr_data = w; rd_pipe = 2'(p);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk("R1 valid", 32'(cfg_valid), 0);
    chk("R1 permit", 32'(tx_permit), 0);
    chk("R1 addr", 32'(dev_addr), 0);
    chk("R1 rd_cfg", 32'(rd_cfg), 0);
    chk("R1 poll", poll_ivl, 0);
  endtask

  task automatic t_activate();
    logic [22:0] w;
    w = mk(1, 1, 4'd0, 2'd0, 2'd0, 3'd6, 2'd1, 8'd5);
    wr(0, w);
    chk("R5 latency", 32'(cfg_valid[0]), 0);
    @(negedge clk);
    chk("R5 valid", 32'(cfg_valid[0]), 1);
    chk("R6 permit", 32'(tx_permit[0]), 1);
    chk("R2 readback", 32'(rd_cfg), 32'(w));
    chk("R8 ctrl ivl", 32'(poll_ivl[7:0]), 0);
  endtask

  task automatic t_lock();
    wr(0, mk(1, 1, 4'd9, 2'd2, 2'd2, 3'd2, 2'd1, 8'd77));
    settle();
    chk("R7 locked", 32'(rd_cfg), 32'(mk(1, 1, 4'd0, 2'd0, 2'd2, 3'd6, 2'd1, 8'd77)));
    chk("R7 still valid", 32'(cfg_valid[0]), 1);
  endtask

  task automatic t_cumulative();
    wr(1, mk(1, 1, 4'd1, 2'd2, 2'd1, 3'd7, 2'd1, 8'd0));
    wr(3, mk(1, 1, 4'd3, 2'd3, 2'd1, 3'd4, 2'd2, 8'd10));
    settle();
    chk("R4 1792 fit", 32'(cfg_valid), 32'b1011);
    chk("R8 intr ivl", 32'(poll_ivl[31:24]), 10);
    wr(2, mk(1, 1, 4'd2, 2'd1, 2'd1, 3'd6, 2'd1, 8'd0));
    settle();
    chk("R4 later pipe overflows", 32'(cfg_valid), 32'b0111);
    chk("R6 no permit overflow", 32'(tx_permit[3]), 0);
    wr(2, mk(1, 0, 4'd2, 2'd1, 2'd1, 3'd6, 2'd1, 8'd0));
    settle();
    chk("R5 alloc clear", 32'(cfg_valid), 32'b1011);
    wr(2, mk(1, 1, 4'd2, 2'd1, 2'd1, 3'd5, 2'd1, 8'd0));
    settle();
    chk("R5 unlocked write", 32'(rd_cfg), 32'(mk(1, 1, 4'd2, 2'd1, 2'd1, 3'd5, 2'd1, 8'd0)));
    chk("R4 exact capacity", 32'(cfg_valid), 32'b1111);
  endtask

  task automatic t_disable();
    wr(1, mk(0, 1, 4'd1, 2'd2, 2'd1, 3'd7, 2'd1, 8'd0));
    chk("R6 permit drops with enable", 32'(tx_permit[1]), 0);
    @(negedge clk);
    chk("R5 enable clear", 32'(cfg_valid[1]), 0);
  endtask

  task automatic t_limits();
    do_reset();
    wr(2, mk(1, 1, 4'd2, 2'd2, 2'd0, 3'd7, 2'd1, 8'd0));
    wr(3, mk(1, 1, 4'd3, 2'd3, 2'd0, 3'd4, 2'd3, 8'd0));
    wr(1, mk(1, 1, 4'd1, 2'd2, 2'd0, 3'd3, 2'd0, 8'd0));
    wr(0, mk(0, 1, 4'd0, 2'd0, 2'd0, 3'd3, 2'd1, 8'd0));
    settle();
    chk("R3 limit breaches", 32'(cfg_valid), 0);
    chk("R3 no permit", 32'(tx_permit), 0);
    wr(0, mk(1, 0, 4'd0, 2'd0, 2'd0, 3'd3, 2'd1, 8'd0));
    settle();
    chk("R3 alloc off", 32'(cfg_valid[0]), 0);
    wr(3, mk(1, 1, 4'd3, 2'd3, 2'd0, 3'd4, 2'd2, 8'd0));
    settle();
    chk("R3 at max", 32'(cfg_valid), 32'b1000);
  endtask

  task automatic t_addr();
    @(negedge clk); addr_we = 1'b1; addr_wdata = 7'h2A;
    @(negedge clk); addr_we = 1'b0;
    chk("R9 write", 32'(dev_addr), 32'h2A);
    repeat (3) @(negedge clk);
    chk("R9 hold", 32'(dev_addr), 32'h2A);
    bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    chk("R10 clear", 32'(dev_addr), 0);
    addr_we = 1'b1; addr_wdata = 7'h7F;
    @(negedge clk);
    chk("R9 max addr", 32'(dev_addr), 32'h7F);
    addr_wdata = 7'h33; bus_reset = 1'b1;
    @(negedge clk); addr_we = 1'b0; bus_reset = 1'b0;
    chk("R10 priority", 32'(dev_addr), 0);
  endtask

  initial begin
    t_reset();
    t_activate();
    t_lock();
    t_cumulative();
    t_disable();
    t_limits();
    t_addr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule